// File: doc/BRIEF.md
# Stereo Bitstream Decimator with Saturation

This block converts two 1-bit oversampled streams, left and right, into signed 18-bit PCM words at the output sample rate. Each stream carries one bit per two system clocks, so the input runs at 128 times the output rate and the system clock runs at 256 times that rate. A bit of 1 counts as +1 and a bit of 0 counts as −1, so the conversion is non-inverting. The stream is reduced by 128 in two stages. The first is a fourth-order comb-integrator stage that divides by 32. The second is an 8-tap symmetric low-pass FIR with coefficients 1,3,5,7,7,5,3,1 that divides by 4. The two channels share one adder chain, one comb chain and one multiplier by taking turns on alternate clocks. The whole path has a DC gain of exactly 2^17, so a full-scale stream of all ones lands on +2^17.

A DC blocker can be switched in after decimation. It computes y = x − x_prev + y_prev − (y_prev >> 10). While the blocker is off, its feedback state is held at zero, so switching it on with a steady input gives zero at once. The result is then clamped to the signed 18-bit range. A near-full-scale flag is updated with every output word. This flag goes high-impedance when the active-low standby input is asserted. Standby also clears all filter state and stops output words.

Top module: `bitstream_decimator`

## Requirements
- R1: `sampleValid` is a one-clock pulse every 256 clocks. The first pulse comes 227 clocks after reset or standby is released. `sampleL`, `sampleR` and `ovld` take their new values in the same cycle as the pulse.
- R2: With the DC blocker off, a stream that has n ones in every 32-bit period settles to exactly (2n − 32)·4096. For example, 24 ones gives +65536, 8 ones gives −65536 and 16 ones gives 0. A stream whose average is positive gives a positive code.
- R3: Results above +131071 clamp to +131071, and results below −131072 clamp to −131072. A stream of all ones gives +131071 and a stream of all zeros gives −131072.
- R4: `bitL` is sampled on even clocks of the phase counter and feeds only `sampleL`. `bitR` is sampled on odd clocks and feeds only `sampleR`.
- R5: With `hpEnable` high, an input that has settled to a steady density gives an output of 0. With `hpEnable` low, the DC level passes through unchanged.
- R6: With the DC blocker on, a step from density 1/2 to all ones settles to a value between 125000 and 131070. This is below the maximum code, and it decays slowly.
- R7: With the DC blocker on, a step from all zeros to all ones overshoots the range and clamps to +131071. The opposite step clamps to −131072.
- R8: `ovld` is high when either channel's output word is at or above +116785 or at or below −116785. Otherwise it is low. A channel with 31 or 1 ones per 32 bits sets the flag. A channel with 30 or 2 ones per 32 bits does not.
- R9: While `standbyN` is low, `ovld` is released to high impedance, no `sampleValid` occurs, and both samples read 0. After release, the output follows the input again from a cleared state.
- R10: Between `sampleValid` pulses, `sampleL`, `sampleR` and `ovld` hold their values. After reset they read 0, and `sampleValid` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256 times the output sample rate |
| rstN | input | 1 | Asynchronous reset, active low |
| standbyN | input | 1 | Standby request, active low |
| hpEnable | input | 1 | Switches the DC blocker in when high |
| bitL | input | 1 | Left modulator bit, held for two clocks |
| bitR | input | 1 | Right modulator bit, held for two clocks |
| sampleL | output | 18 | Left signed PCM word |
| sampleR | output | 18 | Right signed PCM word |
| sampleValid | output | 1 | One-clock strobe marking a new word pair |
| ovld | output | 1 | Near-full-scale flag, high impedance in standby |

## Verification
A new word pair and its flag appear together on the `sampleValid` cycle. That cycle is clock 227 after reset or standby release, and every 256 clocks after that. The bench counts edges to confirm this timing and measures the interval on every pulse. A change in input density reaches its settled output within about five output periods, covering the comb stages, the FIR line and the blocker register. The driver therefore waits for eight pulses after each change and only then queues the expected words. The monitor compares those words against the next pulse, sampling outputs at the falling edge.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  // Decimation structure: comb-integrator stage then FIR stage.
  localparam int CIC_ORDER = 4;
  localparam int CIC_RATE  = 32;
  localparam int FIR_TAPS  = 8;
  localparam int FIR_RATE  = 4;

  localparam int TAP_W = $clog2(FIR_TAPS);
  localparam int BLK_W = $clog2(2 * CIC_RATE);
  localparam int CNT_W = $clog2(2 * CIC_RATE * FIR_RATE);
  localparam int CIC_W = CIC_ORDER * $clog2(CIC_RATE) + 2;
  localparam int COEF_SUM_LOG = $clog2(FIR_TAPS * FIR_TAPS / 2);
  localparam int MAC_W = CIC_W + COEF_SUM_LOG + 1;
  localparam int COEF_W = 5;

  typedef struct packed {
    logic clr;
    logic integ;
    logic comb;
    logic mac;
    logic hp;
    logic out;
    logic ch;
    logic [TAP_W-1:0] tap;
  } strobe_t;
endpackage

// File: rtl/bsd_ctrl.sv
module bsd_ctrl
  import bsd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    standbyN,
  output strobe_t stb
);
  localparam logic [BLK_W-2:0]       HP_SLOT  = (BLK_W-1)'(2 * FIR_TAPS);
  localparam logic [BLK_W-1:0]       OUT_SLOT = BLK_W'(4 * FIR_TAPS + 2);
  localparam logic [CNT_W-BLK_W-1:0] LAST_GRP = (CNT_W-BLK_W)'(FIR_RATE - 1);
  localparam logic [BLK_W-TAP_W-2:0] MAC_SEG  = (BLK_W-TAP_W-1)'(1);

  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] blk;
  logic lastGrp;

  // Phase counter: one full turn per output sample.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (!standbyN) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign blk     = cnt[BLK_W-1:0];
  assign lastGrp = cnt[CNT_W-1:BLK_W] == LAST_GRP;

  always_comb begin
    stb     = '0;
    stb.clr = !standbyN;
    stb.ch  = cnt[0];
    stb.tap = cnt[TAP_W:1];
    if (standbyN) begin
      stb.integ = 1'b1;
      stb.comb  = blk[BLK_W-1:1] == '0;
      stb.mac   = lastGrp && (blk[BLK_W-1:TAP_W+1] == MAC_SEG);
      stb.hp    = lastGrp && (blk[BLK_W-1:1] == HP_SLOT);
      stb.out   = lastGrp && (blk == OUT_SLOT);
    end
  end

  // R1: the output strobe comes right after the right-channel blocker slot
  p_out_after_hp_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.out |-> ($past(stb.hp) && $past(stb.ch)));
  // R1: the multiply-accumulate slots never overlap the blocker slots
  p_mac_before_hp_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.hp |-> !stb.mac);
endmodule

// File: rtl/bsd_core.sv
module bsd_core
  import bsd_pkg::*;
#(
  parameter int OUT_W     = 18,
  parameter int HP_SHIFT  = 10,
  parameter int OVL_LEVEL = 116785
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic                    hpEnable,
  input  logic                    bitL,
  input  logic                    bitR,
  output logic signed [OUT_W-1:0] sampleL,
  output logic signed [OUT_W-1:0] sampleR,
  output logic                    sampleValid,
  output logic                    ovlFlag
);
  localparam int HP_W = MAC_W;
  localparam int FIR_SHIFT = CIC_ORDER * $clog2(CIC_RATE) + COEF_SUM_LOG - (OUT_W - 1);
  localparam logic signed [HP_W-1:0]  MAXV  = HP_W'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [HP_W-1:0]  MINV  = -HP_W'(2 ** (OUT_W - 1));
  localparam logic signed [OUT_W-1:0] OVL_P = OUT_W'(OVL_LEVEL);
  localparam logic signed [OUT_W-1:0] OVL_N = -OUT_W'(OVL_LEVEL);

  logic signed [CIC_W-1:0] integ   [2][CIC_ORDER];
  logic signed [CIC_W-1:0] combDly [2][CIC_ORDER];
  logic signed [CIC_W-1:0] firLine [2][FIR_TAPS];
  logic signed [MAC_W-1:0] macAcc  [2];
  logic signed [HP_W-1:0]  xPrev   [2];
  logic signed [HP_W-1:0]  yPrev   [2];
  logic signed [OUT_W-1:0] sat     [2];

  logic signed [CIC_W-1:0] inVal, combOut, combAcc;
  logic signed [CIC_W-1:0] combTap [CIC_ORDER];
  logic signed [MAC_W-1:0] prod;
  logic signed [HP_W-1:0]  xVal, yVal, preVal;
  logic signed [OUT_W-1:0] satVal;

  function automatic logic signed [COEF_W-1:0] coefOf(input logic [TAP_W-1:0] t);
    int m;
    m = (int'(t) < FIR_TAPS / 2) ? int'(t) : FIR_TAPS - 1 - int'(t);
    return COEF_W'(2 * m + 1);
  endfunction

  assign inVal = (stb.ch ? bitR : bitL) ? CIC_W'(1) : -CIC_W'(1);

  // Shared comb chain for the channel in turn.
  always_comb begin
    combAcc = integ[stb.ch][CIC_ORDER-1];
    for (int k = 0; k < CIC_ORDER; k++) begin
      combTap[k] = combAcc;
      combAcc    = combAcc - combDly[stb.ch][k];
    end
    combOut = combAcc;
  end

  // Shared multiplier and DC blocker.
  always_comb begin
    prod   = MAC_W'(firLine[stb.ch][stb.tap]) * MAC_W'(coefOf(stb.tap));
    xVal   = macAcc[stb.ch] >>> FIR_SHIFT;
    yVal   = xVal - xPrev[stb.ch] + yPrev[stb.ch] - (yPrev[stb.ch] >>> HP_SHIFT);
    preVal = hpEnable ? yVal : xVal;
    if (preVal > MAXV)      satVal = MAXV[OUT_W-1:0];
    else if (preVal < MINV) satVal = MINV[OUT_W-1:0];
    else                    satVal = preVal[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || stb.clr) begin
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < CIC_ORDER; k++) begin
          integ[c][k]   <= '0;
          combDly[c][k] <= '0;
        end
        for (int j = 0; j < FIR_TAPS; j++) firLine[c][j] <= '0;
        macAcc[c] <= '0;
        xPrev[c]  <= '0;
        yPrev[c]  <= '0;
        sat[c]    <= '0;
      end
      sampleL     <= '0;
      sampleR     <= '0;
      sampleValid <= 1'b0;
      ovlFlag     <= 1'b0;
    end else begin
      if (stb.integ) begin
        integ[stb.ch][0] <= integ[stb.ch][0] + inVal;
        for (int k = 1; k < CIC_ORDER; k++)
          integ[stb.ch][k] <= integ[stb.ch][k] + integ[stb.ch][k-1];
      end
      if (stb.comb) begin
        for (int k = 0; k < CIC_ORDER; k++) combDly[stb.ch][k] <= combTap[k];
        firLine[stb.ch][0] <= combOut;
        for (int j = 1; j < FIR_TAPS; j++) firLine[stb.ch][j] <= firLine[stb.ch][j-1];
      end
      if (stb.mac)
        macAcc[stb.ch] <= ((stb.tap == '0) ? '0 : macAcc[stb.ch]) + prod;
      if (stb.hp) begin
        xPrev[stb.ch] <= xVal;
        yPrev[stb.ch] <= hpEnable ? yVal : '0;
        sat[stb.ch]   <= satVal;
      end
      sampleValid <= stb.out;
      if (stb.out) begin
        sampleL <= sat[0];
        sampleR <= sat[1];
        ovlFlag <= (sat[0] >= OVL_P) || (sat[0] <= OVL_N) ||
                   (sat[1] >= OVL_P) || (sat[1] <= OVL_N);
      end
    end
  end

  // R1: the word strobe lasts a single clock
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);
  // R10: words and flag change only with the strobe
  p_hold_between_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.clr |=> (sampleValid || ($stable(sampleL) && $stable(sampleR) && $stable(ovlFlag))));
  // R9: standby silences and clears the outputs
  p_standby_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> (!sampleValid && sampleL == '0 && sampleR == '0));
  // R3: a left result above range lands on the top code
  p_clamp_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.hp && !stb.ch && preVal > MAXV) |=> (sat[0] == MAXV[OUT_W-1:0]));
  // R3: a right result below range lands on the bottom code
  p_clamp_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.hp && stb.ch && preVal < MINV) |=> (sat[1] == MINV[OUT_W-1:0]));
endmodule

// File: rtl/bitstream_decimator.sv
module bitstream_decimator
  import bsd_pkg::*;
#(
  parameter int OUT_W     = 18,
  parameter int HP_SHIFT  = 10,
  parameter int OVL_LEVEL = 116785
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    standbyN,
  input  logic                    hpEnable,
  input  logic                    bitL,
  input  logic                    bitR,
  output logic signed [OUT_W-1:0] sampleL,
  output logic signed [OUT_W-1:0] sampleR,
  output logic                    sampleValid,
  output logic                    ovld
);
  strobe_t stb;
  logic ovlFlag;

  bsd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .standbyN (standbyN),
    .stb      (stb)
  );

  bsd_core #(
    .OUT_W     (OUT_W),
    .HP_SHIFT  (HP_SHIFT),
    .OVL_LEVEL (OVL_LEVEL)
  ) u_core (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .hpEnable    (hpEnable),
    .bitL        (bitL),
    .bitR        (bitR),
    .sampleL     (sampleL),
    .sampleR     (sampleR),
    .sampleValid (sampleValid),
    .ovlFlag     (ovlFlag)
  );

  assign ovld = standbyN ? ovlFlag : 1'bz;
endmodule

// File: tb/sim_bitstream_decimator.sv
module sim_bitstream_decimator;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standbyN = 1'b1;
  logic hpEnable = 1'b0;
  logic bitL = 1'b0;
  logic bitR = 1'b0;
  logic signed [17:0] sampleL, sampleR;
  logic sampleValid;
  wire  ovldNet;
  pullup (ovldNet);

  always #2 clk = ~clk;

  bitstream_decimator u0 (
    .clk         (clk),
    .rstN        (rstN),
    .standbyN    (standbyN),
    .hpEnable    (hpEnable),
    .bitL        (bitL),
    .bitR        (bitR),
    .sampleL     (sampleL),
    .sampleR     (sampleR),
    .sampleValid (sampleValid),
    .ovld        (ovldNet)
  );

  int checks = 0;
  int errors = 0;

  function automatic void record(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endfunction

  // Stimulus generator: n ones at the start of every 32-bit period, one bit per two clocks.
  int onesL = 16;
  int onesR = 16;
  int bitIdx = 0;
  bit phaseB = 1'b0;
  always @(negedge clk) begin
    if (phaseB) begin
      bitL   <= (bitIdx < onesL);
      bitR   <= (bitIdx < onesR);
      bitIdx <= (bitIdx + 1) % 32;
    end
    phaseB <= !phaseB;
  end

  typedef struct {
    int loL;
    int hiL;
    int loR;
    int hiR;
    int ovl;
    string tag;
  } exp_t;
  exp_t q[$];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops one expectation per word strobe.
  int validCount = 0;
  int lastValid = -1;
  always @(negedge clk) begin
    exp_t e;
    if (!standbyN || !rstN) lastValid = -1;
    else if (sampleValid) begin
      validCount++;
      if (lastValid >= 0) record(cyc - lastValid == 256, "R1 strobe period", cyc - lastValid, 256);
      lastValid = cyc;
      if (q.size() > 0) begin
        e = q.pop_front();
        record(int'(sampleL) >= e.loL && int'(sampleL) <= e.hiL, {e.tag, " left"}, int'(sampleL), e.loL);
        record(int'(sampleR) >= e.loR && int'(sampleR) <= e.hiR, {e.tag, " right"}, int'(sampleR), e.loR);
        record(int'(ovldNet) == e.ovl, {e.tag, " flag"}, int'(ovldNet), e.ovl);
      end
    end
  end

  task automatic waitValids(input int n);
    int target;
    target = validCount + n;
    while (validCount < target) @(negedge clk);
  endtask

  task automatic setPattern(input int l, input int r);
    @(negedge clk);
    onesL = l;
    onesR = r;
    waitValids(8);
  endtask

  task automatic expectNext(input int loL, input int hiL, input int loR, input int hiR,
                            input int ovl, input string tag);
    exp_t e;
    e.loL = loL; e.hiL = hiL; e.loR = loR; e.hiR = hiR; e.ovl = ovl; e.tag = tag;
    q.push_back(e);
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic countToFirst(output int n);
    n = 0;
    while (1) begin
      @(posedge clk);
      n++;
      #1;
      if (sampleValid || n > 400) break;
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    record(1'b0, "watchdog expired", cyc, 0);
    finishRun();
  end

  initial begin
    int n;
    int bad;
    repeat (3) @(negedge clk);
    // R10: reset state
    record(sampleValid == 1'b0, "R10 reset strobe", int'(sampleValid), 0);
    record(sampleL == 0 && sampleR == 0, "R10 reset words", int'(sampleL), 0);
    record(ovldNet == 1'b0, "R10 reset flag", int'(ovldNet), 0);
    rstN = 1'b1;
    countToFirst(n);
    record(n == 227, "R1 first word after reset", n, 227);

    // R2 R4: DC levels, independent channels
    setPattern(24, 8);
    expectNext(65536, 65536, -65536, -65536, 0, "R2 R4 densities 3/4 and 1/4");
    setPattern(16, 32);
    expectNext(0, 0, 131071, 131071, 1, "R2 R3 balanced left, full right");
    setPattern(0, 16);
    expectNext(-131072, -131072, 0, 0, 1, "R3 empty left clamps low");

    // R8: flag threshold on both polarities
    setPattern(31, 16);
    expectNext(122880, 122880, 0, 0, 1, "R8 left 31 of 32");
    setPattern(30, 16);
    expectNext(114688, 114688, 0, 0, 0, "R8 left 30 of 32");
    setPattern(16, 1);
    expectNext(0, 0, -122880, -122880, 1, "R8 right 1 of 32");
    setPattern(16, 2);
    expectNext(0, 0, -114688, -114688, 0, "R8 right 2 of 32");

    // R5: blocker removes settled DC
    setPattern(24, 8);
    @(negedge clk) hpEnable = 1'b1;
    waitValids(2);
    expectNext(0, 0, 0, 0, 0, "R5 blocker on steady input");

    // R6: moderate step stays below the top code
    @(negedge clk) hpEnable = 1'b0;
    setPattern(16, 16);
    @(negedge clk) hpEnable = 1'b1;
    waitValids(1);
    setPattern(32, 16);
    expectNext(125000, 131070, 0, 0, 1, "R6 blocker step to full");

    // R7: large steps clamp with the blocker on
    @(negedge clk) hpEnable = 1'b0;
    setPattern(0, 32);
    @(negedge clk) hpEnable = 1'b1;
    waitValids(1);
    setPattern(32, 0);
    expectNext(131071, 131071, -131072, -131072, 1, "R7 blocker full swing clamps");
    @(negedge clk) hpEnable = 1'b0;

    // R9: standby
    setPattern(16, 16);
    expectNext(0, 0, 0, 0, 0, "R9 before standby");
    @(negedge clk) standbyN = 1'b0;
    bad = 0;
    repeat (600) begin
      @(negedge clk);
      if (sampleValid || ovldNet !== 1'b1 || sampleL != 0 || sampleR != 0) bad++;
    end
    record(bad == 0, "R9 standby quiet and released", bad, 0);
    onesL = 24;
    onesR = 8;
    @(negedge clk) standbyN = 1'b1;
    countToFirst(n);
    record(n == 227, "R1 R9 first word after standby", n, 227);
    waitValids(8);
    expectNext(65536, 65536, -65536, -65536, 0, "R9 recovery after standby");

    finishRun();
  end
endmodule